// File: doc/BRIEF.md
# Key-Wakeup and NMI Request Detector

This block turns five raw pin levels into two sticky request flags for an interrupt controller. Four key pins feed one shared key request. A key pin only counts while its direction bit says it is an input. The counted pins are AND-combined, and the request is raised on the falling edge of that AND. As a result, a key held low hides any later press on the other keys until every counted key is high again. A combinational key wake output follows the raw pins with no clock, so it can bring the device out of wait or stop mode.

The non-maskable interrupt pin is synchronized and then passes through a digital debounce filter of programmable length. Once the enable bit is 1, a high-to-low transition of the filtered level raises the NMI request. No mask input exists that could block it. Each flag stays set until a one-cycle clear pulse arrives. The asynchronous active-low reset is released synchronously inside the block.

Top module: `kwd_key_nmi_detect`

## Requirements
- R1: When the AND of all participating key levels falls from 1 to 0, `key_req_o` becomes 1 three clock edges after the raw pin change (two synchronizer stages plus the flag register), and not earlier. A rising AND raises no request.
- R2: A key pin whose `key_dir_i` bit is 1 (output) is treated as high. It neither raises a request nor drives `key_wake_o`. Switching a low pin from output to input counts as a falling edge, and the flag sets on the next clock edge.
- R3: While any participating key is held low, a low on another key raises no request. After all keys return high, a new press raises one again.
- R4: `key_wake_o` is 1 whenever any participating raw key pin is low. `nmi_wake_o` is 1 whenever `nmi_en_i` is 1 and the raw NMI pin is low. Both are combinational and need no clock edge.
- R5: With `nmi_en_i` at 1, a falling edge of the filtered NMI level sets `nmi_req_o`. A rising edge sets nothing.
- R6: With `nmi_en_i` at 0, NMI falling edges set no request and `nmi_wake_o` stays 0.
- R7: For a `dbnc_len_i` value N from 1 to 7, the filter takes a new NMI level only after the synchronized input has differed from the filtered level for N consecutive cycles. `nmi_req_o` rises 3+N edges after the raw change. A pulse shorter than N cycles is dropped.
- R8: A `dbnc_len_i` value of 0 bypasses the filter, and `nmi_req_o` rises 4 edges after the raw change.
- R9: Each flag stays 1 until a clear pulse. A clear with no set in the same cycle drops the flag on the next edge.
- R10: A set and a clear in the same cycle leave the flag at 1.
- R11: During reset, both flags are 0 and all key levels are taken as high. Releasing reset raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_pin_i | input | 4 | Raw key pin levels |
| key_dir_i | input | 4 | Key direction bits, 1 = output (ignored) |
| nmi_pin_i | input | 1 | Raw NMI pin level |
| nmi_en_i | input | 1 | NMI detection enable |
| dbnc_len_i | input | 3 | Debounce length N, 0 = bypass |
| clr_key_i | input | 1 | One-cycle clear of the key flag |
| clr_nmi_i | input | 1 | One-cycle clear of the NMI flag |
| key_req_o | output | 1 | Sticky key request flag |
| nmi_req_o | output | 1 | Sticky NMI request flag |
| key_wake_o | output | 1 | Combinational key wake |
| nmi_wake_o | output | 1 | Combinational NMI wake |

## Verification
The key path is tested with these patterns:
- a single press, which separates edge timing from level sensitivity;
- a second press while the first key is held low, which shows the AND masking and separates it from per-pin edge detection;
- a low pin set as an output and then switched to an input, which shows that direction gating acts after synchronization.

The NMI path is tested with:
- the enable off;
- the filter bypassed;
- lengths 3 and 7, checked one cycle before and at the expected rise, which catches an off-by-one in the counter;
- a two-cycle glitch at length 3, which must be dropped.

A set that coincides with a clear shows which of the two has priority.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  parameter int unsigned KEY_N = 4;
  parameter int unsigned DBW   = 3;
  typedef logic [KEY_N-1:0] key_vec_t;
  typedef logic [DBW-1:0]   dbnc_len_t;
endpackage

// File: rtl/kwd_rst_sync.sv
module kwd_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_o = stg_q[1];
endmodule

// File: rtl/kwd_sync.sv
module kwd_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/kwd_debounce.sv
module kwd_debounce #(
  parameter int unsigned DBW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           din_i,
  input  logic [DBW-1:0] len_i,
  output logic           lvl_o
);
  logic [DBW-1:0] cnt_q, cnt_d;
  logic           lvl_q, lvl_d;
  logic [DBW:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = cnt_q;
    if (len_i == '0) begin
      lvl_d = din_i;
      cnt_d = '0;
    end else if (din_i == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_inc == {1'b0, len_i}) begin
      lvl_d = din_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_inc[DBW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      cnt_q <= cnt_d;
    end
  end

  assign lvl_o = lvl_q;

  // R7: a matching input never moves the filtered level
  p_filt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (len_i != '0 && din_i == lvl_q) |=> $stable(lvl_q));
  // R8: bypass follows the input one cycle later
  p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (len_i == '0) |=> (lvl_q == $past(din_i)));
endmodule

// File: rtl/kwd_flag.sv
module kwd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_q);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> (q_q == $past(q_q)));
endmodule

// File: rtl/kwd_key_nmi_detect.sv
module kwd_key_nmi_detect
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_N-1:0] key_pin_i,
  input  logic [KEY_N-1:0] key_dir_i,
  input  logic             nmi_pin_i,
  input  logic             nmi_en_i,
  input  logic [DBW-1:0]   dbnc_len_i,
  input  logic             clr_key_i,
  input  logic             clr_nmi_i,
  output logic             key_req_o,
  output logic             nmi_req_o,
  output logic             key_wake_o,
  output logic             nmi_wake_o
);
  logic     rst_int_n;
  key_vec_t key_sync;
  logic     key_all_hi, key_prev_q, key_fall;
  logic     nmi_sync, nmi_filt, nmi_prev_q, nmi_fall;

  kwd_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n));

  kwd_sync #(.W(KEY_N), .RST_VAL(1'b1)) u_key_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(key_pin_i), .q_o(key_sync));

  kwd_sync #(.W(1), .RST_VAL(1'b1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(nmi_pin_i), .q_o(nmi_sync));

  kwd_debounce #(.DBW(DBW)) u_dbnc (
    .clk(clk), .rst_n(rst_int_n), .din_i(nmi_sync),
    .len_i(dbnc_len_i), .lvl_o(nmi_filt));

  // output-direction pins are forced high before the AND
  assign key_all_hi = &(key_sync | key_dir_i);
  assign key_fall   = key_prev_q & ~key_all_hi;
  assign nmi_fall   = nmi_en_i & nmi_prev_q & ~nmi_filt;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      key_prev_q <= 1'b1;
      nmi_prev_q <= 1'b1;
    end else begin
      key_prev_q <= key_all_hi;
      nmi_prev_q <= nmi_filt;
    end
  end

  kwd_flag u_key_flag (.clk(clk), .rst_n(rst_int_n), .set_i(key_fall),
                       .clr_i(clr_key_i), .q_o(key_req_o));
  kwd_flag u_nmi_flag (.clk(clk), .rst_n(rst_int_n), .set_i(nmi_fall),
                       .clr_i(clr_nmi_i), .q_o(nmi_req_o));

  assign key_wake_o = ~&(key_pin_i | key_dir_i);
  assign nmi_wake_o = nmi_en_i & ~nmi_pin_i;

  p_dir_out_ignored_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (&key_dir_i) |=> !$rose(key_req_o));
  p_nmi_disabled_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !nmi_en_i |=> !$rose(nmi_req_o));
  p_key_rise_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (key_all_hi && !clr_key_i) |=> (key_req_o == $past(key_req_o)));
  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_int_n |-> (!key_req_o && !nmi_req_o));
endmodule

// File: tb/kwd_key_nmi_detect_tb.sv
module kwd_key_nmi_detect_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] key_pin, key_dir;
  logic       nmi_pin, nmi_en, clr_key, clr_nmi;
  logic [2:0] dbnc_len;
  logic       key_req, nmi_req, key_wake, nmi_wake;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    at;
    int    sig;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kwd_key_nmi_detect u_dut (
    .clk(clk), .rst_n(rst_n), .key_pin_i(key_pin), .key_dir_i(key_dir),
    .nmi_pin_i(nmi_pin), .nmi_en_i(nmi_en), .dbnc_len_i(dbnc_len),
    .clr_key_i(clr_key), .clr_nmi_i(clr_nmi), .key_req_o(key_req),
    .nmi_req_o(nmi_req), .key_wake_o(key_wake), .nmi_wake_o(nmi_wake));

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: pop expected items as their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      chk(e.tag, (e.sig == 0) ? key_req : nmi_req, e.val);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_in(int d, int sig, bit val, string tag);
    exp_t e;
    e.at = cyc + d; e.sig = sig; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drain();
    while (sb.size() > 0) tick(1);
  endtask

  task automatic clear_key();
    clr_key = 1'b1; expect_in(1, 0, 1'b0, "R9 key clear");
    tick(1); clr_key = 1'b0; drain();
  endtask

  task automatic clear_nmi();
    clr_nmi = 1'b1; expect_in(1, 1, 1'b0, "R9 nmi clear");
    tick(1); clr_nmi = 1'b0; drain();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; key_pin = 4'hF; key_dir = 4'h0; nmi_pin = 1'b1;
    nmi_en = 1'b0; dbnc_len = 3'd0; clr_key = 1'b0; clr_nmi = 1'b0;
    tick(3);
    chk("R11 reset key_req", key_req, 1'b0);
    chk("R11 reset nmi_req", nmi_req, 1'b0);
    chk("R11 reset key_wake", key_wake, 1'b0);
    rst_n = 1'b1;
    expect_in(6, 0, 1'b0, "R11 no key edge after reset");
    expect_in(6, 1, 1'b0, "R11 no nmi edge after reset");
    drain();

    // R1 single press, R4 wake
    key_pin[0] = 1'b0; #1;
    chk("R4 key wake", key_wake, 1'b1);
    expect_in(2, 0, 1'b0, "R1 not early");
    expect_in(3, 0, 1'b1, "R1 press");
    drain();
    key_pin = 4'hF;
    expect_in(5, 0, 1'b1, "R9 flag persists");
    drain();
    clear_key();

    // R3 masking by a held key
    key_pin[0] = 1'b0;
    expect_in(3, 0, 1'b1, "R1 press key0");
    drain();
    clear_key();
    key_pin[1] = 1'b0;
    expect_in(3, 0, 1'b0, "R3 hidden press");
    expect_in(6, 0, 1'b0, "R3 hidden press later");
    drain();
    key_pin[0] = 1'b1;
    expect_in(4, 0, 1'b0, "R3 key1 still low");
    drain();
    key_pin[1] = 1'b1;
    expect_in(4, 0, 1'b0, "R1 rising no request");
    drain();
    key_pin[2] = 1'b0;
    expect_in(3, 0, 1'b1, "R3 press after release");
    drain();
    key_pin = 4'hF; tick(4);
    clear_key();

    // R2 direction gating
    key_dir = 4'b0100; key_pin = 4'b1011; #1;
    chk("R2 output pin no wake", key_wake, 1'b0);
    expect_in(3, 0, 1'b0, "R2 output pin ignored");
    expect_in(5, 0, 1'b0, "R2 output pin ignored later");
    drain();
    key_dir = 4'b0000;
    expect_in(1, 0, 1'b1, "R2 switch to input");
    drain();
    key_pin = 4'hF; tick(4);
    clear_key();

    // R10 set and clear together
    key_pin[3] = 1'b0;
    tick(2);
    clr_key = 1'b1;
    expect_in(1, 0, 1'b1, "R10 set wins");
    tick(1);
    clr_key = 1'b0;
    expect_in(1, 0, 1'b1, "R10 set held");
    drain();
    key_pin = 4'hF; tick(4);
    clear_key();

    // R6 NMI disabled
    nmi_pin = 1'b0; #1;
    chk("R6 no nmi wake", nmi_wake, 1'b0);
    expect_in(4, 1, 1'b0, "R6 disabled");
    expect_in(7, 1, 1'b0, "R6 disabled later");
    drain();
    nmi_pin = 1'b1; tick(6);

    // R8 bypass, R5 enable
    nmi_en = 1'b1;
    nmi_pin = 1'b0; #1;
    chk("R4 nmi wake", nmi_wake, 1'b1);
    expect_in(3, 1, 1'b0, "R8 not early");
    expect_in(4, 1, 1'b1, "R8 bypass edge");
    drain();
    nmi_pin = 1'b1;
    expect_in(6, 1, 1'b1, "R5 flag persists");
    drain();
    clear_nmi();
    expect_in(3, 1, 1'b0, "R5 rising no request");
    drain();

    // R7 length 3
    dbnc_len = 3'd3; tick(4);
    nmi_pin = 1'b0;
    expect_in(5, 1, 1'b0, "R7 len3 not early");
    expect_in(6, 1, 1'b1, "R7 len3 edge");
    drain();
    nmi_pin = 1'b1; tick(8);
    clear_nmi();

    // R7 short glitch dropped
    nmi_pin = 1'b0; tick(2); nmi_pin = 1'b1;
    expect_in(5, 1, 1'b0, "R7 glitch dropped");
    expect_in(9, 1, 1'b0, "R7 glitch dropped later");
    drain();

    // R7 length 7
    dbnc_len = 3'd7; tick(4);
    nmi_pin = 1'b0;
    expect_in(9, 1, 1'b0, "R7 len7 not early");
    expect_in(10, 1, 1'b1, "R7 len7 edge");
    drain();
    nmi_pin = 1'b1; tick(12);
    clear_nmi();

    tick(2);
    finish_run();
  end
endmodule